// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences a small processor core between three operating states: running, idle and power-down. Software selects a state by writing a two-bit mode register. From the current state the block derives three enables: one gating the CPU clock, one gating the peripheral clocks and one for the oscillator. It also decides what the address-latch strobe, the program-fetch strobe and the four 8-bit ports show at the pins.

While running, the pin values come straight from the core. In idle and power-down they follow a fixed table. That table depends on whether program code is fetched from on-chip or off-chip memory. The code-memory select pin is sampled only while reset is held, and later changes on it have no effect.

Idle ends when an enabled interrupt is pending. The core then resumes and enters its service routine. Power-down ends only through a hardware reset. All interfaces are plain level or strobe signals, with no valid/ready handshake and no back-pressure.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst` is high the block is running (`mode_o`=0), `ctl_q`=0 and all three enables are 1. The value of `ext_code` is captured only while `rst` is high, and later changes on it do not alter the pin table.
- R2: `mode_o` encodes the state: 0 running, 1 idle, 2 power-down.
- R3: A running-state write with bit 0 (idle) set and bit 1 clear enters idle at the next clock edge. In idle, `cpu_clk_en`=0, `per_clk_en`=1 and `osc_en`=1.
- R4: A running-state write with bit 1 (power-down) set enters power-down at the next clock edge, even if bit 0 is also set. In power-down, all three enables are 0.
- R5: After a running-state write, `ctl_q` holds the written bits. A write of 0 leaves the block running.
- R6: In idle, a high `irq_pend` returns the block to running at the next edge and clears both bits of `ctl_q`.
- R7: In power-down, `irq_pend` has no effect. Only `rst` returns the block to running.
- R8: Register writes made in idle or power-down are ignored.
- R9: While running, `ale_o`, `psen_o`, `p0_oe` and `p0_o`..`p3_o` equal their `*_run` inputs.
- R10: In idle, `ale_o` and `psen_o` are 1. In power-down, both are 0.
- R11: With on-chip code (captured `ext_code`=0), each port `pN_o` outputs its `pN_dat` in both low-power states, and `p0_oe`=1.
- R12: With off-chip code (captured `ext_code`=1), port 0 floats in both low-power states (`p0_oe`=0, `p0_o`=0). Ports 1 and 3 output their data. Port 2 outputs `addr_hi` in idle and `p2_dat` in power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| ext_code | input | 1 | Code-memory select pin, 1 = off-chip |
| ctl_we | input | 1 | Mode register write strobe |
| ctl_wdata | input | 2 | Write data: bit 0 idle, bit 1 power-down |
| irq_pend | input | 1 | An enabled interrupt is pending |
| ale_run | input | 1 | Address-latch strobe from the core |
| psen_run | input | 1 | Program-fetch strobe from the core |
| p0_oe_run | input | 1 | Port 0 drive enable from the core |
| p0_run | input | 8 | Port 0 value from the core |
| p1_run | input | 8 | Port 1 value from the core |
| p2_run | input | 8 | Port 2 value from the core |
| p3_run | input | 8 | Port 3 value from the core |
| p0_dat | input | 8 | Port 0 data latch |
| p1_dat | input | 8 | Port 1 data latch |
| p2_dat | input | 8 | Port 2 data latch |
| p3_dat | input | 8 | Port 3 data latch |
| addr_hi | input | 8 | Upper code-address byte |
| ctl_q | output | 2 | Mode register contents |
| mode_o | output | 2 | Current state |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| ale_o | output | 1 | Address-latch strobe pin |
| psen_o | output | 1 | Program-fetch strobe pin |
| p0_oe | output | 1 | Port 0 drive enable |
| p0_o | output | 8 | Port 0 pin value |
| p1_o | output | 8 | Port 1 pin value |
| p2_o | output | 8 | Port 2 pin value |
| p3_o | output | 8 | Port 3 pin value |

## Verification
Assertions check several rules on every cycle:
- the state moves that follow a write, including power-down taking priority over idle;
- the one-cycle exit from idle on an interrupt;
- power-down staying put until reset;
- the mode register staying unchanged under writes made in a low-power state;
- the captured code-memory select holding after reset;
- the clock enables matching the state, and port 0 floating with off-chip code.

Only the bench scenarios show the full pin table. The bench covers every write value under both captured code-memory settings, compares every port value against its source, and shows that a change on the select pin after reset leaves the table as it was.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int IDLE_BIT = 0;
  localparam int PD_BIT   = 1;
  localparam int CTL_W    = 2;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_IDLE = 2'd1,
    ST_PD   = 2'd2
  } lpm_state_e;

  typedef struct packed {
    logic cpu;
    logic per;
    logic osc;
  } clk_en_t;
endpackage

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             irq_pend,
  output logic [CTL_W-1:0] ctl_q,
  output lpm_state_e       state
);
  lpm_state_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_RUN;
      ctl_q <= '0;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (ctl_we) begin
            ctl_q <= ctl_wdata;
            if (ctl_wdata[PD_BIT])        st_q <= ST_PD;
            else if (ctl_wdata[IDLE_BIT]) st_q <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (irq_pend) begin
            st_q  <= ST_RUN;
            ctl_q <= '0;
          end
        end
        ST_PD: ;
        default: st_q <= ST_RUN;
      endcase
    end
  end

  assign state = st_q;

  a_r4_pd_wins: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && ctl_we && ctl_wdata[PD_BIT]) |=> (st_q == ST_PD));
  a_r3_idle_entry: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && ctl_we && ctl_wdata == 2'b01) |=> (st_q == ST_IDLE));
  a_r6_irq_exit: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && irq_pend) |=> (st_q == ST_RUN && ctl_q == '0));
  a_r7_pd_sticky: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PD) |=> (st_q == ST_PD));
  a_r8_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_RUN && ctl_we && !irq_pend) |=> $stable(ctl_q));
endmodule

// File: rtl/lpm_clken.sv
module lpm_clken
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  lpm_state_e state,
  output clk_en_t    en
);
  always_comb begin
    unique case (state)
      ST_IDLE: en = '{cpu: 1'b0, per: 1'b1, osc: 1'b1};
      ST_PD:   en = '{cpu: 1'b0, per: 1'b0, osc: 1'b0};
      default: en = '{cpu: 1'b1, per: 1'b1, osc: 1'b1};
    endcase
  end

  a_r3_idle_clocks: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (!en.cpu && en.per && en.osc));
  a_r4_pd_clocks: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PD) |-> (en == 3'b000));
endmodule

// File: rtl/lpm_pinmux.sv
module lpm_pinmux
  import lpm_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int NPORT  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  lpm_state_e                    state,
  input  logic                          ext_code,
  input  logic                          ale_run,
  input  logic                          psen_run,
  input  logic                          p0_oe_run,
  input  logic [NPORT-1:0][PORT_W-1:0]  run_v,
  input  logic [NPORT-1:0][PORT_W-1:0]  dat_v,
  input  logic [PORT_W-1:0]             addr_hi,
  output logic                          ale_o,
  output logic                          psen_o,
  output logic                          p0_oe,
  output logic [NPORT-1:0][PORT_W-1:0]  pin_v
);
  localparam int FLOAT_PORT = 0;
  localparam int ADDR_PORT  = 2;

  logic running;
  assign running = (state == ST_RUN);

  always_comb begin
    unique case (state)
      ST_IDLE: begin ale_o = 1'b1;    psen_o = 1'b1;     end
      ST_PD:   begin ale_o = 1'b0;    psen_o = 1'b0;     end
      default: begin ale_o = ale_run; psen_o = psen_run; end
    endcase
    p0_oe = running ? p0_oe_run : !ext_code;
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    logic floats, shows_addr;
    assign floats     = (i == FLOAT_PORT) && ext_code;
    assign shows_addr = (i == ADDR_PORT) && ext_code && (state == ST_IDLE);
    always_comb begin
      if (running)         pin_v[i] = run_v[i];
      else if (floats)     pin_v[i] = '0;
      else if (shows_addr) pin_v[i] = addr_hi;
      else                 pin_v[i] = dat_v[i];
    end
  end

  a_r12_p0_float: assert property (@(posedge clk) disable iff (rst)
    (state != ST_RUN && ext_code) |-> (!p0_oe && pin_v[FLOAT_PORT] == '0));
  a_r10_strobes: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PD) |-> (!ale_o && !psen_o));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_code,
  input  logic              ctl_we,
  input  logic [1:0]        ctl_wdata,
  input  logic              irq_pend,
  input  logic              ale_run,
  input  logic              psen_run,
  input  logic              p0_oe_run,
  input  logic [PORT_W-1:0] p0_run,
  input  logic [PORT_W-1:0] p1_run,
  input  logic [PORT_W-1:0] p2_run,
  input  logic [PORT_W-1:0] p3_run,
  input  logic [PORT_W-1:0] p0_dat,
  input  logic [PORT_W-1:0] p1_dat,
  input  logic [PORT_W-1:0] p2_dat,
  input  logic [PORT_W-1:0] p3_dat,
  input  logic [PORT_W-1:0] addr_hi,
  output logic [1:0]        ctl_q,
  output logic [1:0]        mode_o,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              osc_en,
  output logic              ale_o,
  output logic              psen_o,
  output logic              p0_oe,
  output logic [PORT_W-1:0] p0_o,
  output logic [PORT_W-1:0] p1_o,
  output logic [PORT_W-1:0] p2_o,
  output logic [PORT_W-1:0] p3_o
);
  localparam int NPORT = 4;

  lpm_state_e state;
  clk_en_t    en;
  logic       ext_lat;
  logic [NPORT-1:0][PORT_W-1:0] run_v, dat_v, pin_v;

  always_ff @(posedge clk) begin
    if (rst) ext_lat <= ext_code;
  end

  a_r1_select_held: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(ext_lat));

  assign run_v = {p3_run, p2_run, p1_run, p0_run};
  assign dat_v = {p3_dat, p2_dat, p1_dat, p0_dat};

  lpm_fsm u_fsm (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .irq_pend(irq_pend), .ctl_q(ctl_q), .state(state)
  );

  lpm_clken u_clken (
    .clk(clk), .rst(rst), .state(state), .en(en)
  );

  lpm_pinmux #(.PORT_W(PORT_W), .NPORT(NPORT)) u_pinmux (
    .clk(clk), .rst(rst), .state(state), .ext_code(ext_lat),
    .ale_run(ale_run), .psen_run(psen_run), .p0_oe_run(p0_oe_run),
    .run_v(run_v), .dat_v(dat_v), .addr_hi(addr_hi),
    .ale_o(ale_o), .psen_o(psen_o), .p0_oe(p0_oe), .pin_v(pin_v)
  );

  assign mode_o     = state;
  assign cpu_clk_en = en.cpu;
  assign per_clk_en = en.per;
  assign osc_en     = en.osc;
  assign p0_o = pin_v[0];
  assign p1_o = pin_v[1];
  assign p2_o = pin_v[2];
  assign p3_o = pin_v[3];
endmodule

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, ext_code, ctl_we, irq_pend, ale_run, psen_run, p0_oe_run;
  logic [1:0] ctl_wdata, ctl_q, mode_o;
  logic [7:0] p0_run, p1_run, p2_run, p3_run, p0_dat, p1_dat, p2_dat, p3_dat, addr_hi;
  logic cpu_clk_en, per_clk_en, osc_en, ale_o, psen_o, p0_oe;
  logic [7:0] p0_o, p1_o, p2_o, p3_o;

  lpm_ctrl u_lpm_ctrl (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_inputs(int k);
    ale_run = k[0]; psen_run = k[1]; p0_oe_run = k[2];
    p0_run = 8'h10 + 8'(k); p1_run = 8'h20 + 8'(k);
    p2_run = 8'h30 + 8'(k); p3_run = 8'h40 + 8'(k);
    p0_dat = 8'h80 + 8'(k); p1_dat = 8'h90 + 8'(k);
    p2_dat = 8'hA0 + 8'(k); p3_dat = 8'hB0 + 8'(k);
    addr_hi = 8'hC0 + 8'(k);
  endtask

  // expected pins: m = 0 running, 1 idle, 2 power-down; e = captured select
  task automatic chk_pins(int m, bit e);
    if (m == 0) begin
      chk("R9 ale", ale_o, ale_run);     chk("R9 psen", psen_o, psen_run);
      chk("R9 p0oe", p0_oe, p0_oe_run); chk("R9 p0", p0_o, p0_run);
      chk("R9 p1", p1_o, p1_run);       chk("R9 p2", p2_o, p2_run);
      chk("R9 p3", p3_o, p3_run);
    end else begin
      chk("R10 ale", ale_o, (m == 1));
      chk("R10 psen", psen_o, (m == 1));
      chk("R11/R12 p0oe", p0_oe, !e);
      chk("R11/R12 p0", p0_o, e ? 8'h00 : p0_dat);
      chk("R11/R12 p1", p1_o, p1_dat);
      chk("R11/R12 p2", p2_o, (e && m == 1) ? addr_hi : p2_dat);
      chk("R11/R12 p3", p3_o, p3_dat);
    end
  endtask

  task automatic chk_clocks(int m);
    chk("R3/R4 cpu_en", cpu_clk_en, (m == 0));
    chk("R3/R4 per_en", per_clk_en, (m != 2));
    chk("R3/R4 osc_en", osc_en, (m != 2));
  endtask

  initial begin
    #1600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1; ext_code = 0; ctl_we = 0; ctl_wdata = 0; irq_pend = 0;
    set_inputs(0);
    for (int e = 0; e < 2; e++) begin
      for (int w = 0; w < 4; w++) begin
        int m;
        m = w[1] ? 2 : (w[0] ? 1 : 0);
        // reset with select captured, then flip it (R1)
        @(negedge clk); rst = 1; ext_code = e[0];
        @(negedge clk); @(negedge clk);
        rst = 0; ext_code = !e[0];
        @(negedge clk);
        chk("R1 mode", mode_o, 0); chk("R1 ctl", ctl_q, 0); chk_clocks(0);
        set_inputs(e * 4 + w + 1);
        @(negedge clk);
        chk_pins(0, e[0]);
        // write the mode register
        ctl_we = 1; ctl_wdata = w[1:0];
        @(negedge clk);
        ctl_we = 0;
        chk("R2/R3/R4 mode", mode_o, m);
        chk("R5 ctl", ctl_q, w);
        chk_clocks(m);
        chk_pins(m, e[0]);
        // write attempt in a low-power state (R8)
        if (m != 0) begin
          ctl_we = 1; ctl_wdata = (w == 3) ? 2'b01 : 2'b11;
          @(negedge clk);
          ctl_we = 0;
          chk("R8 ctl", ctl_q, w); chk("R8 mode", mode_o, m);
          chk_pins(m, e[0]);
        end
        // interrupt (R6, R7)
        irq_pend = 1;
        @(negedge clk);
        irq_pend = 0;
        if (m == 1) begin
          chk("R6 mode", mode_o, 0); chk("R6 ctl", ctl_q, 0); chk_clocks(0);
          chk_pins(0, e[0]);
        end else if (m == 2) begin
          @(negedge clk);
          chk("R7 mode", mode_o, 2); chk("R7 ctl", ctl_q, w); chk_clocks(2);
        end else begin
          chk("R5 mode", mode_o, 0);
        end
      end
    end
    // reset leaves power-down (R7)
    @(negedge clk); ctl_we = 1; ctl_wdata = 2'b10;
    @(negedge clk); ctl_we = 0;
    chk("R4 mode", mode_o, 2);
    rst = 1;
    @(negedge clk);
    chk("R7 reset exit", mode_o, 0); chk("R1 ctl", ctl_q, 0);
    rst = 0;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule